// File: doc/BRIEF.md
# Paged Dual-Port RAM

This block is a single-clock storage array divided into a parameterized number of equal pages, reached through two symmetric ports. Each port carries a private page pointer. Callers drive only a word index that lies inside a page. A single-cycle step pulse moves that port's pointer to the following page. The usual use is a rotating buffer. One port fills a page while the other drains a different page. Both ports then step and the roles rotate through the pages with no idle cycles.

A parameter selects one of three internal ways of forming the physical address:

- separate storage per page, with an output multiplexer driven by the page number;
- the page number concatenated above the word index;
- the page number times the page size, added to the word index.

The ports cannot tell the three apart. A clock enable freezes all state.

Top module: `paged_dual_ram`

## Requirements
- R1: A synchronous reset, acting whether or not the clock enable is high, returns port A's pointer to START_A and port B's pointer to START_B, and clears both read-valid outputs. The defaults are START_A = 0 and START_B = 1.
- R2: Each port's address input is ceil(log2(PAGE_SZ)) bits wide. It selects word `addr` of the port's current page, and different pages hold separate words.
- R3: The two page pointers are independent. Stepping one port never moves the other.
- R4: A high step input with the clock enable high advances that port's pointer by one. The pointer wraps from page PAGES-1 to page 0. Without a step the pointer holds.
- R5: Read data appears on the clock after a cycle with read enable high, and read-valid is high in exactly that cycle. After a cycle with read enable low, read-valid is low.
- R6: An access made in the same cycle as a step pulse goes to the old page. The access in the very next cycle goes to the new page, so pages can be used back to back.
- R7: The three address styles (per-page banks, concatenated, scaled-and-added) give identical read data and read-valid in every cycle.
- R8: With the clock enable low there are no memory writes and no pointer steps, and read data and read-valid hold their values.
- R9: Either port can write and either port can read. A word written through one port reads back through the other.
- R10: With write enable low the memory is unchanged. With read enable low, read data keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable for all state |
| a_step | input | 1 | Port A advance-page pulse |
| a_addr | input | ceil(log2(PAGE_SZ)) | Port A word index within its page |
| a_wen | input | 1 | Port A write enable |
| a_wdat | input | DATA_W | Port A write data |
| a_ren | input | 1 | Port A read enable |
| a_rdat | output | DATA_W | Port A read data |
| a_rval | output | 1 | Port A read data valid |
| b_step | input | 1 | Port B advance-page pulse |
| b_addr | input | ceil(log2(PAGE_SZ)) | Port B word index within its page |
| b_wen | input | 1 | Port B write enable |
| b_wdat | input | DATA_W | Port B write data |
| b_ren | input | 1 | Port B read enable |
| b_rdat | output | DATA_W | Port B read data |
| b_rval | output | 1 | Port B read data valid |

## Verification
The embedded properties check three things on every cycle. First, the pointer steps by one with wrap-around and otherwise holds. Second, read-valid follows read enable with one cycle of delay. Third, a low clock enable freezes both read outputs.

Stored contents are outside the reach of those properties, so the bench's scenarios are what show them. Those scenarios cover:

- page isolation, and the wrap of the pointer seen through the data;
- hand-over at a step pulse in the same cycle as an access;
- cross-port visibility;
- dropped writes under a low clock enable;
- agreement of the three address styles, shown by running all three side by side against an arithmetic model of the pages.

// File: rtl/paged_ram_pkg.sv
package paged_ram_pkg;

   // Physical address composition used inside the page store
   typedef enum logic [1:0] {
      PG_STYLE_MUX = 2'd0,   // one bank per page, output selected by page
      PG_STYLE_CAT = 2'd1,   // {page, word} concatenation
      PG_STYLE_SUM = 2'd2    // page * page size + word
   } pg_style_e;

endpackage

// File: rtl/paged_ram_ptr.sv
module paged_ram_ptr #(
   parameter int PAGES = 2,
   parameter int START = 0,
   parameter int PW    = 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          cke,
   input  logic          step,
   output logic [PW-1:0] page
);

   localparam logic [PW-1:0] LAST  = PW'(PAGES - 1);
   localparam logic [PW-1:0] FIRST = PW'(START);

   always_ff @(posedge clk) begin
      if (rst) begin
         page <= FIRST;
      end else if (cke && step) begin
         page <= (page == LAST) ? '0 : page + PW'(1);
      end
   end

   AST_PAGE_STEP: assert property (@(posedge clk) disable iff (rst)
      (cke && step) |=> (page == (($past(page) == LAST) ? '0 : $past(page) + PW'(1))));  // R4
   AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !(cke && step) |=> $stable(page));  // R4
   AST_PAGE_RANGE: assert property (@(posedge clk) disable iff (rst)
      page <= LAST);  // R4

endmodule

// File: rtl/paged_ram_store.sv
module paged_ram_store
   import paged_ram_pkg::*;
#(
   parameter pg_style_e STYLE = PG_STYLE_MUX,
   parameter int DW    = 8,
   parameter int PAGES = 2,
   parameter int PSZ   = 8,
   parameter int AW    = 3,
   parameter int PW    = 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          cke,
   input  logic [PW-1:0] pg_a,
   input  logic [AW-1:0] ad_a,
   input  logic          we_a,
   input  logic [DW-1:0] wd_a,
   input  logic          re_a,
   output logic [DW-1:0] rq_a,
   output logic          rv_a,
   input  logic [PW-1:0] pg_b,
   input  logic [AW-1:0] ad_b,
   input  logic          we_b,
   input  logic [DW-1:0] wd_b,
   input  logic          re_b,
   output logic [DW-1:0] rq_b,
   output logic          rv_b
);

   // read-valid pipeline shared by all styles
   always_ff @(posedge clk) begin
      if (rst) begin
         rv_a <= 1'b0;
         rv_b <= 1'b0;
      end else if (cke) begin
         rv_a <= re_a;
         rv_b <= re_b;
      end
   end

   generate
      if (STYLE == PG_STYLE_MUX) begin : g_mux
         logic [DW-1:0] word_a [PAGES];
         logic [DW-1:0] word_b [PAGES];
         for (genvar p = 0; p < PAGES; p++) begin : g_bank
            logic [DW-1:0] bank [PSZ];
            always_ff @(posedge clk) begin
               if (cke) begin
                  if (we_a && pg_a == PW'(p)) bank[ad_a] <= wd_a;
                  if (we_b && pg_b == PW'(p)) bank[ad_b] <= wd_b;
               end
            end
            assign word_a[p] = bank[ad_a];
            assign word_b[p] = bank[ad_b];
         end
         always_ff @(posedge clk) begin
            if (cke) begin
               if (re_a) rq_a <= word_a[pg_a];
               if (re_b) rq_b <= word_b[pg_b];
            end
         end
      end else begin : g_flat
         localparam int CW  = PW + AW;
         localparam int DEP = (STYLE == PG_STYLE_CAT) ? (1 << CW) : PAGES * PSZ;
         localparam int XW  = $clog2(DEP);
         logic [XW-1:0] ix_a, ix_b;
         logic [DW-1:0] mem [DEP];
         if (STYLE == PG_STYLE_CAT) begin : g_cat
            assign ix_a = {pg_a, ad_a};
            assign ix_b = {pg_b, ad_b};
         end else begin : g_sum
            assign ix_a = XW'(pg_a) * XW'(PSZ) + XW'(ad_a);
            assign ix_b = XW'(pg_b) * XW'(PSZ) + XW'(ad_b);
         end
         always_ff @(posedge clk) begin
            if (cke) begin
               if (we_a) mem[ix_a] <= wd_a;
               if (we_b) mem[ix_b] <= wd_b;
               if (re_a) rq_a <= mem[ix_a];
               if (re_b) rq_b <= mem[ix_b];
            end
         end
      end
   endgenerate

   AST_RVAL_A_LATENCY: assert property (@(posedge clk) disable iff (rst)
      cke |=> (rv_a == $past(re_a)));  // R5
   AST_RVAL_B_LATENCY: assert property (@(posedge clk) disable iff (rst)
      cke |=> (rv_b == $past(re_b)));  // R5
   AST_CKE_FREEZE_A: assert property (@(posedge clk) disable iff (rst)
      !cke |=> ($stable(rv_a) && $stable(rq_a)));  // R8
   AST_CKE_FREEZE_B: assert property (@(posedge clk) disable iff (rst)
      !cke |=> ($stable(rv_b) && $stable(rq_b)));  // R8

endmodule

// File: rtl/paged_dual_ram.sv
module paged_dual_ram
   import paged_ram_pkg::*;
#(
   parameter pg_style_e STYLE = PG_STYLE_MUX,
   parameter int DATA_W  = 8,
   parameter int PAGES   = 2,
   parameter int PAGE_SZ = 8,
   parameter int START_A = 0,
   parameter int START_B = 1,
   localparam int AW = $clog2(PAGE_SZ)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cke,
   input  logic              a_step,
   input  logic [AW-1:0]     a_addr,
   input  logic              a_wen,
   input  logic [DATA_W-1:0] a_wdat,
   input  logic              a_ren,
   output logic [DATA_W-1:0] a_rdat,
   output logic              a_rval,
   input  logic              b_step,
   input  logic [AW-1:0]     b_addr,
   input  logic              b_wen,
   input  logic [DATA_W-1:0] b_wdat,
   input  logic              b_ren,
   output logic [DATA_W-1:0] b_rdat,
   output logic              b_rval
);

   localparam int PW = $clog2(PAGES);

   generate
      if (PAGES < 2) begin : g_bad_pages
         $error("paged_dual_ram: PAGES must be at least 2");
      end
      if (PAGE_SZ < 2) begin : g_bad_size
         $error("paged_dual_ram: PAGE_SZ must be at least 2");
      end
      if (START_A >= PAGES || START_B >= PAGES) begin : g_bad_start
         $error("paged_dual_ram: start pages must be below PAGES");
      end
   endgenerate

   logic [PW-1:0] pg_a, pg_b;

   paged_ram_ptr #(.PAGES(PAGES), .START(START_A), .PW(PW)) u_ptr_a (
      .clk(clk), .rst(rst), .cke(cke), .step(a_step), .page(pg_a));

   paged_ram_ptr #(.PAGES(PAGES), .START(START_B), .PW(PW)) u_ptr_b (
      .clk(clk), .rst(rst), .cke(cke), .step(b_step), .page(pg_b));

   paged_ram_store #(
      .STYLE(STYLE), .DW(DATA_W), .PAGES(PAGES), .PSZ(PAGE_SZ), .AW(AW), .PW(PW)
   ) u_store (
      .clk(clk), .rst(rst), .cke(cke),
      .pg_a(pg_a), .ad_a(a_addr), .we_a(a_wen), .wd_a(a_wdat), .re_a(a_ren),
      .rq_a(a_rdat), .rv_a(a_rval),
      .pg_b(pg_b), .ad_b(b_addr), .we_b(b_wen), .wd_b(b_wdat), .re_b(b_ren),
      .rq_b(b_rdat), .rv_b(b_rval));

endmodule

// File: tb/paged_dual_ram_test.sv
module paged_dual_ram_test;
   import paged_ram_pkg::*;

   localparam int DW  = 8;
   localparam int NP  = 3;
   localparam int PSZ = 8;
   localparam int AW  = 3;
   localparam int NS  = 3;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst, cke;
   logic a_step, a_wen, a_ren, b_step, b_wen, b_ren;
   logic [AW-1:0] a_addr, b_addr;
   logic [DW-1:0] a_wdat, b_wdat;
   logic [DW-1:0] a_rdat [NS];
   logic [DW-1:0] b_rdat [NS];
   logic          a_rval [NS];
   logic          b_rval [NS];

   generate
      for (genvar s = 0; s < NS; s++) begin : g_st
         localparam pg_style_e ST = pg_style_e'(s);
         paged_dual_ram #(.STYLE(ST), .DATA_W(DW), .PAGES(NP), .PAGE_SZ(PSZ),
                          .START_A(0), .START_B(1)) uut (
            .clk(clk), .rst(rst), .cke(cke),
            .a_step(a_step), .a_addr(a_addr), .a_wen(a_wen), .a_wdat(a_wdat),
            .a_ren(a_ren), .a_rdat(a_rdat[s]), .a_rval(a_rval[s]),
            .b_step(b_step), .b_addr(b_addr), .b_wen(b_wen), .b_wdat(b_wdat),
            .b_ren(b_ren), .b_rdat(b_rdat[s]), .b_rval(b_rval[s]));
      end
   endgenerate

   // arithmetic model of the pages and pointers
   logic [DW-1:0] mdl [NP*PSZ];
   bit            known [NP*PSZ];
   int            pa, pb;
   logic          ea_v, eb_v;
   logic [DW-1:0] ea_d, eb_d;
   bit            ea_k, eb_k;
   int            n_chk = 0;
   int            n_bad = 0;

   task automatic chk(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic quiet();
      a_step = 0; a_wen = 0; a_ren = 0; a_addr = '0; a_wdat = '0;
      b_step = 0; b_wen = 0; b_ren = 0; b_addr = '0; b_wdat = '0;
   endtask

   function automatic logic [DW-1:0] pat(int seed, int p, int a);
      return DW'(seed * 37 + p * 11 + a * 3 + 1);
   endfunction

   // one clock: predict, advance model at the edge, compare at the falling edge
   task automatic tick(string req);
      int ia = pa * PSZ + int'(a_addr);
      int ib = pb * PSZ + int'(b_addr);
      if (rst) begin
         ea_v = 0; eb_v = 0;
      end else if (cke) begin
         ea_v = a_ren; eb_v = b_ren;
         if (a_ren) begin ea_d = mdl[ia]; ea_k = known[ia]; end
         if (b_ren) begin eb_d = mdl[ib]; eb_k = known[ib]; end
      end
      @(posedge clk);
      if (cke) begin
         if (a_wen) begin mdl[ia] = a_wdat; known[ia] = 1; end
         if (b_wen) begin mdl[ib] = b_wdat; known[ib] = 1; end
      end
      if (rst) begin
         pa = 0; pb = 1;
      end else if (cke) begin
         if (a_step) pa = (pa + 1) % NP;
         if (b_step) pb = (pb + 1) % NP;
      end
      @(negedge clk);
      for (int s = 0; s < NS; s++) begin
         chk(req, "a_rval", int'(a_rval[s]), int'(ea_v));
         chk(req, "b_rval", int'(b_rval[s]), int'(eb_v));
         if (ea_k) chk(req, "a_rdat", int'(a_rdat[s]), int'(ea_d));
         if (eb_k) chk(req, "b_rdat", int'(b_rdat[s]), int'(eb_d));
         if (s > 0) begin
            chk("R7", "a_rval style match", int'(a_rval[s]), int'(a_rval[0]));
            chk("R7", "b_rval style match", int'(b_rval[s]), int'(b_rval[0]));
            if (ea_k) chk("R7", "a_rdat style match", int'(a_rdat[s]), int'(a_rdat[0]));
            if (eb_k) chk("R7", "b_rdat style match", int'(b_rdat[s]), int'(b_rdat[0]));
         end
      end
   endtask

   task automatic do_reset();
      rst = 1; quiet();
      repeat (3) tick("R1");
      rst = 0;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      #(4 * 100000);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      for (int i = 0; i < NP * PSZ; i++) known[i] = 0;
      pa = 0; pb = 1; ea_k = 0; eb_k = 0; ea_v = 0; eb_v = 0;
      cke = 1;
      do_reset();

      // R2: port A fills every page, stepping on each last word (wraps to page 0)
      for (int p = 0; p < NP; p++)
         for (int a = 0; a < PSZ; a++) begin
            quiet();
            a_wen = 1; a_addr = AW'(a); a_wdat = pat(0, p, a); a_step = (a == PSZ - 1);
            tick("R2");
         end

      // R4: port B reads all pages starting from page 1, wrapping back
      for (int p = 0; p < NP; p++)
         for (int a = 0; a < PSZ; a++) begin
            quiet();
            b_ren = 1; b_addr = AW'(a); b_step = (a == PSZ - 1);
            tick("R4");
         end

      // R6: back-to-back ping-pong, A fills while B drains, both step on last word
      for (int r = 1; r <= 3 * NP; r++)
         for (int a = 0; a < PSZ; a++) begin
            quiet();
            a_wen = 1; a_addr = AW'(a); a_wdat = pat(r, pa, a);
            b_ren = 1; b_addr = AW'(PSZ - 1 - a);
            a_step = (a == PSZ - 1); b_step = (a == PSZ - 1);
            tick("R6");
         end

      // R5: isolated reads, then idle cycles drop read-valid
      quiet(); a_ren = 1; a_addr = 3; tick("R5");
      quiet(); tick("R5");
      quiet(); b_ren = 1; b_addr = 6; tick("R5");
      quiet(); tick("R5");

      // R9: B writes its page, A steps alone (R3) until it reaches that page, then reads it
      for (int a = 0; a < PSZ; a++) begin
         quiet(); b_wen = 1; b_addr = AW'(a); b_wdat = pat(50, pb, a); tick("R9");
      end
      while (pa != pb) begin
         quiet(); a_step = 1; tick("R3");
      end
      for (int a = 0; a < PSZ; a++) begin
         quiet(); a_ren = 1; a_addr = AW'(a); tick("R9");
      end

      // R8: clock enable low blocks writes, steps and read updates
      quiet(); a_ren = 1; a_addr = 1; b_ren = 1; b_addr = 2; tick("R8");
      cke = 0;
      for (int i = 0; i < 3; i++) begin
         quiet();
         a_wen = 1; a_addr = AW'(2 + i); a_wdat = 8'hEE; a_ren = 1; a_step = 1;
         b_wen = 1; b_addr = AW'(5); b_wdat = 8'h5A; b_ren = 1; b_step = 1;
         tick("R8");
      end
      cke = 1;
      for (int a = 0; a < PSZ; a++) begin
         quiet(); a_ren = 1; a_addr = AW'(a); b_ren = 1; b_addr = AW'(a); tick("R8");
      end

      // R10: enables low with busy address and data lines
      for (int i = 0; i < 4; i++) begin
         quiet(); a_addr = AW'(i); a_wdat = 8'hC3; b_addr = AW'(i + 4); b_wdat = 8'h3C;
         tick("R10");
      end
      for (int a = 0; a < PSZ; a++) begin
         quiet(); a_ren = 1; a_addr = AW'(a); b_ren = 1; b_addr = AW'(a); tick("R10");
      end

      // R1: reset after pointers moved returns them to their start pages
      quiet(); a_step = 1; tick("R1");
      do_reset();
      for (int a = 0; a < PSZ; a++) begin
         quiet(); a_ren = 1; a_addr = AW'(a); b_ren = 1; b_addr = AW'(a); tick("R1");
      end
      quiet(); tick("R1");

      finish_run();
   end

endmodule